// File: doc/BRIEF.md
# Atomic Quadword Load Unit

This unit handles one kind of memory instruction: a load-double-alternate whose address-space identifier (ASI) selects a physically addressed 128-bit atomic load. It looks at the instruction word in the cycle it is offered and takes ownership of it only when the selected ASI is one of the two quadword ASIs. It then forms the effective address, runs the trap checks in a fixed priority order, and issues a single 128-bit read on a simple request/acknowledge memory port. The returned line is split into an even/odd pair of 64-bit destination registers. The little-endian ASI reverses the bytes inside each 64-bit half.

Both register writes happen in the same cycle, together with a one-cycle completion pulse. As a result, no other access can observe half of the load. When a check fails, no memory read is issued and no register is written. The completion pulse then carries an exception code instead.

The unit takes one instruction at a time. While `busy` is high, further offers are ignored. Address translation, caches and the wider pipeline are outside the unit.

Top module: `qload_unit`

## Requirements
- R1: An offer (`issue_valid` high while `busy` is low) is claimed only when `instr_word[31:30]` is 2'b11 and the selected ASI equals 8'h34 (big-endian form) or 8'h3C (little-endian form). Any other offer produces no `busy`, no `mem_req`, no `done` and no register write.
- R2: The effective address is `rs1_val + rs2_val` when `instr_word[13]` is 0. When `instr_word[13]` is 1, it is `rs1_val` plus the sign-extended 13-bit value in `instr_word[12:0]`.
- R3: The ASI is taken from `instr_word[12:5]` when `instr_word[13]` is 0, and from `asi_reg` when `instr_word[13]` is 1.
- R4: `mem_rdata[127:64]` is the lower-address doubleword and `mem_rdata[63:0]` is the higher-address one, each with its lowest-address byte in the top byte lane. For ASI 8'h34, the even register `rd = instr_word[29:25]` receives the lower-address doubleword unchanged, and register `rd+1` receives the higher-address one.
- R5: For ASI 8'h3C, the pairing of halves to registers is the same as in R4, but the 8 bytes inside each half are written in reversed order.
- R6: Both register writes (indices `rd` and `rd+1`) occur in the same cycle. An odd `rd` yields exception code 1 (illegal instruction).
- R7: An effective address with any of bits 3:0 set yields code 3 (misaligned), and no memory request is made.
- R8: A claimed load with `tgt_cacheable` low yields code 4 (data access), and no memory request is made.
- R9: A claimed instruction whose `instr_word[24:19]` is not 6'b010011 yields code 4 (data access).
- R10: The exception priority, highest first, is: wrong opcode (4), odd `rd` (1), `priv_mode` low (2, privileged action), misaligned (3), noncacheable (4). Code 0 means no exception.
- R11: `mem_req` rises in the cycle after the claim. It stays high with a stable `mem_addr` until `mem_ack` is sampled high. The register writes and `done` appear in the cycle after that acknowledge.
- R12: `done` is a one-cycle pulse. For an exception, it comes in the cycle after the claim, with no register write. `busy` is high from the cycle after the claim until `done`, and offers made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| instr_word | input | 32 | Instruction word |
| rs1_val | input | 64 | First source register value |
| rs2_val | input | 64 | Second source register value |
| asi_reg | input | 8 | Current ASI register value |
| priv_mode | input | 1 | Privileged mode flag |
| tgt_cacheable | input | 1 | Target cacheability attribute |
| busy | output | 1 | A claimed instruction is in progress |
| mem_req | output | 1 | 128-bit read request |
| mem_addr | output | 64 | Physical read address |
| mem_ack | input | 1 | Memory acknowledges, data valid |
| mem_rdata | input | 128 | Read data line |
| wr_even_en | output | 1 | Even register write enable |
| wr_even_idx | output | 5 | Even register index |
| wr_even_data | output | 64 | Even register data |
| wr_odd_en | output | 1 | Odd register write enable |
| wr_odd_idx | output | 5 | Odd register index |
| wr_odd_data | output | 64 | Odd register data |
| done | output | 1 | Completion pulse |
| exc_code | output | 3 | Exception code, valid with done |

## Verification
The hardest condition to reach from the ports is a new offer arriving while a read is still waiting for its acknowledge. If that offer were wrongly taken, it would move the held address or produce a second completion. The stimulus reaches this state by delaying `mem_ack` several cycles, driving a second valid quadword instruction during that wait, and then confirming that the address is unchanged and that exactly one completion with the first instruction's indices follows. Priority is exercised by one instruction that fails three checks at once, so that only the highest-ranked code can appear.

// File: rtl/qload_pkg.sv
package qload_pkg;
   typedef enum logic [2:0] {
      EXC_NONE    = 3'd0,
      EXC_ILLEGAL = 3'd1,
      EXC_PRIV    = 3'd2,
      EXC_ALIGN   = 3'd3,
      EXC_ACCESS  = 3'd4
   } exc_e;

   localparam logic [1:0] OP_MEMORY = 2'b11;
   localparam logic [5:0] OP3_LDDA  = 6'b010011;
   localparam int         ASI_W     = 8;
   localparam int         RIDX_W    = 5;
   localparam int         SIMM_W    = 13;
   localparam int         LINE_B    = 16;
endpackage

// File: rtl/qload_decode.sv
module qload_decode
   import qload_pkg::*;
#(
   parameter int                XLEN   = 64,
   parameter int                ADDR_W = 64,
   parameter logic [ASI_W-1:0]  ASI_BE = 8'h34,
   parameter logic [ASI_W-1:0]  ASI_LE = 8'h3C
) (
   input  logic [31:0]       instr,
   input  logic [XLEN-1:0]   rs1_val,
   input  logic [XLEN-1:0]   rs2_val,
   input  logic [ASI_W-1:0]  asi_reg,
   input  logic              priv_mode,
   input  logic              tgt_cacheable,
   output logic              claim,
   output logic              little,
   output exc_e              exc,
   output logic [RIDX_W-1:0] rd,
   output logic [ADDR_W-1:0] addr
);
   localparam int ALIGN_B = $clog2(LINE_B);

   logic              imm_mode;
   logic [ASI_W-1:0]  asi_sel;
   logic [XLEN-1:0]   offset;
   logic [XLEN-1:0]   ea;
   logic              unused_fields;

   assign imm_mode = instr[13];
   assign rd       = instr[29:25];

   // R3: ASI source follows the i flag
   assign asi_sel  = imm_mode ? asi_reg : instr[12:5];
   assign little   = (asi_sel == ASI_LE);
   // R1: claim only memory-format words carrying a quadword ASI
   assign claim    = (instr[31:30] == OP_MEMORY) &&
                     ((asi_sel == ASI_BE) || (asi_sel == ASI_LE));

   // R2: register or sign-extended immediate offset
   assign offset = imm_mode ? {{(XLEN-SIMM_W){instr[SIMM_W-1]}}, instr[SIMM_W-1:0]}
                            : rs2_val;
   assign ea     = rs1_val + offset;

   generate
      if (ADDR_W == XLEN) begin : g_addr_full
         assign addr = ea;
      end else begin : g_addr_trunc
         logic [XLEN-ADDR_W-1:0] unused_hi;
         assign unused_hi = ea[XLEN-1:ADDR_W];
         assign addr      = ea[ADDR_W-1:0];
      end
   endgenerate

   // R10: fixed priority of the trap checks
   always_comb begin
      exc = EXC_NONE;
      if (instr[24:19] != OP3_LDDA)     exc = EXC_ACCESS;   // R9
      else if (instr[25])               exc = EXC_ILLEGAL;  // R6
      else if (!priv_mode)              exc = EXC_PRIV;
      else if (|ea[ALIGN_B-1:0])        exc = EXC_ALIGN;    // R7
      else if (!tgt_cacheable)          exc = EXC_ACCESS;   // R8
   end

   assign unused_fields = ^{instr[18:14], instr[4:0]};
endmodule

// File: rtl/qload_half_fmt.sv
module qload_half_fmt #(
   parameter int W = 64
) (
   input  logic         little,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int NB = W / 8;

   logic [W-1:0] swapped;

   // R5: mirror byte lanes within the half
   generate
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign swapped[8*b +: 8] = din[W-8-8*b +: 8];
      end
   endgenerate

   assign dout = little ? swapped : din;
endmodule

// File: rtl/qload_unit.sv
module qload_unit
   import qload_pkg::*;
#(
   parameter int               XLEN   = 64,
   parameter int               ADDR_W = 64,
   parameter logic [7:0]       ASI_BE = 8'h34,
   parameter logic [7:0]       ASI_LE = 8'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [31:0]       instr_word,
   input  logic [XLEN-1:0]   rs1_val,
   input  logic [XLEN-1:0]   rs2_val,
   input  logic [7:0]        asi_reg,
   input  logic              priv_mode,
   input  logic              tgt_cacheable,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [2*XLEN-1:0] mem_rdata,
   output logic              wr_even_en,
   output logic [4:0]        wr_even_idx,
   output logic [XLEN-1:0]   wr_even_data,
   output logic              wr_odd_en,
   output logic [4:0]        wr_odd_idx,
   output logic [XLEN-1:0]   wr_odd_data,
   output logic              done,
   output logic [2:0]        exc_code
);
   localparam int LINE_W = 2 * XLEN;

   generate
      if (XLEN % 8 != 0) begin : g_bad_xlen
         $error("XLEN must be a whole number of bytes");
      end
      if (ADDR_W < 4 || ADDR_W > XLEN) begin : g_bad_addr
         $error("ADDR_W must lie between 4 and XLEN");
      end
      if (ASI_BE == ASI_LE) begin : g_bad_asi
         $error("the two quadword ASIs must differ");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_REQ, S_FIN} state_e;

   state_e            state;
   logic              dec_claim, dec_little;
   exc_e              dec_exc, exc_q;
   logic [4:0]        dec_rd, rd_q;
   logic [ADDR_W-1:0] dec_addr, addr_q;
   logic              little_q;
   logic [XLEN-1:0]   even_q, odd_q;
   logic [XLEN-1:0]   fmt_half [2];
   logic              accept;

   qload_decode #(
      .XLEN(XLEN), .ADDR_W(ADDR_W), .ASI_BE(ASI_BE), .ASI_LE(ASI_LE)
   ) u_decode (
      .instr(instr_word), .rs1_val(rs1_val), .rs2_val(rs2_val),
      .asi_reg(asi_reg), .priv_mode(priv_mode), .tgt_cacheable(tgt_cacheable),
      .claim(dec_claim), .little(dec_little), .exc(dec_exc),
      .rd(dec_rd), .addr(dec_addr)
   );

   // R4: half 0 is the lower-address doubleword in the upper lanes
   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         qload_half_fmt #(.W(XLEN)) u_fmt (
            .little(little_q),
            .din(mem_rdata[LINE_W-1-h*XLEN -: XLEN]),
            .dout(fmt_half[h])
         );
      end
   endgenerate

   // R12: offers are only taken while idle
   assign accept = issue_valid && (state == S_IDLE) && dec_claim;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         exc_q    <= EXC_NONE;
         rd_q     <= '0;
         addr_q   <= '0;
         little_q <= 1'b0;
         even_q   <= '0;
         odd_q    <= '0;
      end else begin
         case (state)
            S_IDLE: if (accept) begin
               exc_q    <= dec_exc;
               rd_q     <= dec_rd;
               addr_q   <= dec_addr;
               little_q <= dec_little;
               state    <= (dec_exc == EXC_NONE) ? S_REQ : S_FIN;
            end
            S_REQ: if (mem_ack) begin
               even_q <= fmt_half[0];
               odd_q  <= fmt_half[1];
               state  <= S_FIN;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy         = (state != S_IDLE);
   assign mem_req      = (state == S_REQ);
   assign mem_addr     = addr_q;
   assign done         = (state == S_FIN);
   assign exc_code     = done ? 3'(exc_q) : 3'd0;
   assign wr_even_en   = done && (exc_q == EXC_NONE);
   assign wr_odd_en    = done && (exc_q == EXC_NONE);
   assign wr_even_idx  = rd_q;
   assign wr_odd_idx   = {rd_q[4:1], 1'b1};
   assign wr_even_data = even_q;
   assign wr_odd_data  = odd_q;

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
   p_write_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_even_en |-> $past(mem_req && mem_ack));
   p_pair_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_even_en |-> wr_odd_en && !wr_even_idx[0] && (wr_odd_idx == 5'(wr_even_idx + 5'd1)));
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_exc_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done && (exc_code != 3'd0) |-> !wr_even_en && !wr_odd_en);
   p_aligned_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[3:0] == 4'd0));
   p_busy_after_claim_r12: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
endmodule

// File: tb/qload_unit_tb.sv
module qload_unit_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue_valid = 1'b0;
   logic [31:0]  instr_word = '0;
   logic [63:0]  rs1_val = '0, rs2_val = '0;
   logic [7:0]   asi_reg = '0;
   logic         priv_mode = 1'b1, tgt_cacheable = 1'b1;
   logic         busy, mem_req, mem_ack = 1'b0;
   logic [63:0]  mem_addr;
   logic [127:0] mem_rdata = '0;
   logic         wr_even_en, wr_odd_en, done;
   logic [4:0]   wr_even_idx, wr_odd_idx;
   logic [63:0]  wr_even_data, wr_odd_data;
   logic [2:0]   exc_code;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   qload_unit u_dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr_word(instr_word),
      .rs1_val(rs1_val), .rs2_val(rs2_val), .asi_reg(asi_reg), .priv_mode(priv_mode),
      .tgt_cacheable(tgt_cacheable), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .wr_even_en(wr_even_en),
      .wr_even_idx(wr_even_idx), .wr_even_data(wr_even_data), .wr_odd_en(wr_odd_en),
      .wr_odd_idx(wr_odd_idx), .wr_odd_data(wr_odd_data), .done(done), .exc_code(exc_code)
   );

   task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(logic [4:0] rd, logic [5:0] op3, logic i, logic [12:0] low);
      return {2'b11, rd, op3, 5'd1, i, low};
   endfunction

   function automatic logic [63:0] rev8(logic [63:0] v);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = v[56-8*k +: 8];
      return r;
   endfunction

   // offer for one cycle; returns at the negedge after the claiming edge
   task automatic offer(logic [31:0] iw, logic [63:0] a, logic [63:0] b);
      @(negedge clk);
      instr_word = iw; rs1_val = a; rs2_val = b; issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic expect_exc(string req, logic [2:0] code);
      check(req, "done", {127'd0, done}, 128'd1);
      check(req, "exc_code", {125'd0, exc_code}, {125'd0, code});
      check(req, "no write", {126'd0, wr_even_en, wr_odd_en}, 128'd0);
      check(req, "no mem_req", {127'd0, mem_req}, 128'd0);
      @(negedge clk);
      check(req, "done pulse end", {126'd0, done, mem_req}, 128'd0);
   endtask

   task automatic serve(string req, logic [63:0] ea, int wait_cyc, logic [127:0] line);
      check(req, "mem_req up", {127'd0, mem_req}, 128'd1);
      check("R2", "mem_addr", {64'd0, mem_addr}, {64'd0, ea});
      for (int c = 0; c < wait_cyc; c++) begin
         @(negedge clk);
         check("R11", "req held", {63'd0, mem_req, mem_addr}, {63'd0, 1'b1, ea});
         check("R11", "no early done", {127'd0, done}, 128'd0);
      end
      mem_ack = 1'b1; mem_rdata = line;
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = '0;
   endtask

   task automatic t_reset;
      check("R12", "reset busy/done", {125'd0, busy, done, mem_req}, 128'd0);
      check("R6", "reset writes", {126'd0, wr_even_en, wr_odd_en}, 128'd0);
   endtask

   task automatic t_big_endian_reg_offset;
      logic [127:0] line = 128'h0011223344556677_8899AABBCCDDEEFF;
      priv_mode = 1; tgt_cacheable = 1;
      offer(mk(5'd4, 6'b010011, 1'b0, {8'h34, 5'd2}), 64'h1_0000, 64'h30);
      serve("R11", 64'h1_0030, 3, line);
      check("R11", "done after ack", {124'd0, done, exc_code}, {124'd0, 1'b1, 3'd0});
      check("R6", "both enables", {126'd0, wr_even_en, wr_odd_en}, 128'd3);
      check("R6", "indices", {118'd0, wr_even_idx, wr_odd_idx}, {118'd0, 5'd4, 5'd5});
      check("R4", "even data", {64'd0, wr_even_data}, {64'd0, 64'h0011223344556677});
      check("R4", "odd data", {64'd0, wr_odd_data}, {64'd0, 64'h8899AABBCCDDEEFF});
      @(negedge clk);
      check("R12", "idle after", {125'd0, done, busy, wr_even_en}, 128'd0);
   endtask

   task automatic t_little_endian_asi_reg;
      logic [127:0] line = 128'h0102030405060708_A1A2A3A4A5A6A7A8;
      asi_reg = 8'h3C;
      // R3: immediate field reads as ASI 0xFF, ignored because i=1
      offer(mk(5'd10, 6'b010011, 1'b1, 13'h1FF0), 64'h2000, 64'h0);
      serve("R2", 64'h1FF0, 1, line);
      check("R5", "even reversed", {64'd0, wr_even_data}, {64'd0, rev8(64'h0102030405060708)});
      check("R5", "odd reversed", {64'd0, wr_odd_data}, {64'd0, rev8(64'hA1A2A3A4A5A6A7A8)});
      check("R5", "indices", {118'd0, wr_even_idx, wr_odd_idx}, {118'd0, 5'd10, 5'd11});
      @(negedge clk);
   endtask

   task automatic t_ignored;
      asi_reg = 8'h34;
      // R1/R3: i=0 with immediate ASI 0x80, ASI register not consulted
      offer(mk(5'd2, 6'b010011, 1'b0, {8'h80, 5'd3}), 64'h0, 64'h0);
      for (int c = 0; c < 3; c++) begin
         check("R1", "not claimed", {124'd0, busy, done, mem_req, wr_even_en}, 128'd0);
         @(negedge clk);
      end
      // R1: format bits not 2'b11
      offer({2'b10, mk(5'd2, 6'b010011, 1'b0, {8'h34, 5'd3})}[31:0] & 32'h7FFF_FFFF, 64'h0, 64'h0);
      check("R1", "wrong format ignored", {125'd0, busy, done, mem_req}, 128'd0);
   endtask

   task automatic t_odd_rd;
      offer(mk(5'd7, 6'b010011, 1'b0, {8'h34, 5'd2}), 64'h100, 64'h0);
      expect_exc("R6", 3'd1);
   endtask

   task automatic t_priv_priority;
      priv_mode = 0; tgt_cacheable = 0;
      offer(mk(5'd2, 6'b010011, 1'b0, {8'h3C, 5'd2}), 64'h108, 64'h0);
      expect_exc("R10", 3'd2);
      priv_mode = 1; tgt_cacheable = 1;
   endtask

   task automatic t_misaligned;
      tgt_cacheable = 0;
      offer(mk(5'd2, 6'b010011, 1'b0, {8'h34, 5'd2}), 64'h1000, 64'h8);
      expect_exc("R7", 3'd3);
      tgt_cacheable = 1;
   endtask

   task automatic t_noncache;
      tgt_cacheable = 0;
      offer(mk(5'd2, 6'b010011, 1'b0, {8'h34, 5'd2}), 64'h1000, 64'h10);
      expect_exc("R8", 3'd4);
      tgt_cacheable = 1;
   endtask

   task automatic t_wrong_opcode;
      offer(mk(5'd3, 6'b000011, 1'b0, {8'h3C, 5'd2}), 64'h101, 64'h0);
      expect_exc("R9", 3'd4);
   endtask

   task automatic t_busy_ignore;
      int dones = 0;
      offer(mk(5'd8, 6'b010011, 1'b0, {8'h34, 5'd2}), 64'h4000, 64'h0);
      instr_word = mk(5'd12, 6'b010011, 1'b0, {8'h34, 5'd2});
      rs1_val = 64'h8000; issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      check("R12", "busy while waiting", {127'd0, busy}, 128'd1);
      serve("R12", 64'h4000, 2, 128'h1);
      check("R12", "first instr completes", {122'd0, done, wr_even_idx}, {122'd0, 1'b1, 5'd8});
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         dones += done;
         check("R12", "no second request", {127'd0, mem_req}, 128'd0);
      end
      check("R12", "single completion", dones, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_big_endian_reg_offset();
      t_little_endian_asi_reg();
      t_ignored();
      t_odd_rd();
      t_priv_priority();
      t_misaligned();
      t_noncache();
      t_wrong_opcode();
      t_busy_ignore();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule